// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. A processor-style write port loads one byte into a holding buffer. When the shift stage is free, the byte moves from the buffer into the shift stage and is sent as a frame on `txd`. Because of the buffer, software can queue the next byte while the current frame is still going out, so frames follow each other without gaps.

Each frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. The block produces two status flags. The buffer-empty flag shows that a new byte may be written. The transmit-complete flag shows that the line has gone quiet after the last frame. Each flag has its own interrupt request, gated by its own enable.

A request to switch the transmitter off waits until every queued bit has been sent. Only then does the block release the pin, by dropping `txd_oe`. An external baud generator supplies a one-cycle `baud_tick`, and every serial bit lasts 16 such ticks.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `txd_oe` is 0, `flag_empty` is 1, `flag_txc` is 0 and `irq_txc` is 0.
- R2: A frame has the following parts, in this order:
  - a start bit of 0;
  - the data bits, least significant bit first, where `fmt_width` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits;
  - the optional parity bit;
  - one stop bit of 1, or two stop bits when `fmt_stop2` is 1.

  Every bit lasts 16 `baud_tick` pulses, and the line stays at 1 between frames.
- R3: When `fmt_par_en` is 1, the parity bit sits between the last data bit and the first stop bit. Its value is the XOR of the selected data bits, inverted when `fmt_par_odd` is 1.
- R4: A `wr_en` pulse drives `flag_empty` low one cycle later. No other input (`txc_ack`, `txc_clr`, the enables, `baud_tick`) lowers it, and a write is accepted even while the transmitter is disabled.
- R5: When the transmitter is enabled and the shift stage is idle, a buffered byte moves into the shift stage on the next cycle. `flag_empty` rises and the start bit begins on that same edge, two cycles after the write.
- R6: A byte written while a frame is in progress waits in the buffer, with `flag_empty` held low. It is sent immediately after the current frame, and bytes come out in the order they were written.
- R7: `flag_txc` sets only when the last stop bit of a frame ends and the buffer is empty. It does not set between back-to-back frames.
- R8: `flag_txc` clears one cycle after a `txc_ack` pulse, or one cycle after a `txc_clr` pulse.
- R9: `irq_empty` is high exactly while `ie_empty` and `flag_empty` are both 1.
- R10: `irq_txc` is high exactly while `ie_txc` and `flag_txc` are both 1.
- R11: `txd_oe` rises one cycle after `tx_en` rises. When `tx_en` drops, pending frames are still sent, and `txd_oe` falls one cycle after `flag_txc` sets, with `txd` back at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable request |
| fmt_width | input | 2 | Data width code (0..3 gives 5..8 bits) |
| fmt_par_en | input | 1 | Insert a parity bit |
| fmt_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| fmt_stop2 | input | 1 | Two stop bits when 1 |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Data byte to send |
| txc_clr | input | 1 | Write-one-to-clear strobe for the transmit-complete flag |
| txc_ack | input | 1 | Interrupt acknowledge for the transmit-complete request |
| ie_empty | input | 1 | Enable for the buffer-empty interrupt |
| ie_txc | input | 1 | Enable for the transmit-complete interrupt |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| txd | output | 1 | Serial data out |
| txd_oe | output | 1 | Output enable for the serial pin |
| flag_empty | output | 1 | Transmit buffer empty |
| flag_txc | output | 1 | Transmit complete |
| irq_empty | output | 1 | Buffer-empty interrupt request (level) |
| irq_txc | output | 1 | Transmit-complete interrupt request |

## Verification
The bench checks the buffer-to-shift handover cycle by cycle. A design that left the byte in the buffer, or delayed the rise of `flag_empty`, would miss the check at the second cycle after the write.

It queues a second byte during a frame and confirms that the transmit-complete flag waits until both frames are on the line. A design that set the flag after every frame would fire between them.

It drops the enable while two bytes are still pending. A design that released the pin at once would truncate the queued frames, or raise `txd_oe` again at the wrong time.

Randomized formats and tick rates exercise every width, both parity senses and both stop lengths. A wrong parity XOR or a wrong bit count would show up as a decoded frame that does not match.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int DW  = 8;   // widest data field
    localparam int FW  = 12;  // start + 8 data + parity + 2 stop
    localparam int LW  = 4;   // width of a bit count up to FW

    typedef enum logic [1:0] {
        WID5 = 2'd0,
        WID6 = 2'd1,
        WID7 = 2'd2,
        WID8 = 2'd3
    } width_e;

    typedef struct packed {
        width_e width;
        logic   par_en;
        logic   par_odd;
        logic   stop2;
    } fmt_t;

    typedef struct packed {
        logic [FW-1:0] bits;  // bit 0 leaves first
        logic [LW-1:0] len;
    } frame_t;

    function automatic int data_len(width_e w);
        return 5 + int'(w);
    endfunction

    function automatic logic calc_parity(logic [DW-1:0] d, width_e w, logic odd);
        logic p;
        p = odd;
        for (int i = 0; i < DW; i++) begin
            if (i < data_len(w)) p = p ^ d[i];
        end
        return p;
    endfunction

    function automatic frame_t build_frame(logic [DW-1:0] d, fmt_t f);
        frame_t fr;
        int     pos;
        fr.bits    = '1;
        fr.bits[0] = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < data_len(f.width)) fr.bits[1+i] = d[i];
        end
        pos = 1 + data_len(f.width);
        if (f.par_en) begin
            fr.bits[pos] = calc_parity(d, f.width, f.par_odd);
            pos = pos + 1;
        end
        pos    = pos + (f.stop2 ? 2 : 1);
        fr.len = LW'(pos);
        return fr;
    endfunction

endpackage

// File: rtl/utx_holdbuf.sv
module utx_holdbuf
    import utx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic [DW-1:0] data,
    output logic          empty
);

    logic [DW-1:0] data_q;
    logic          empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            empty_q <= 1'b1;
        end else begin
            if (wr_en) data_q <= wr_data;
            if (wr_en)     empty_q <= 1'b0;
            else if (take) empty_q <= 1'b1;
        end
    end

    assign data  = data_q;
    assign empty = empty_q;

    // R4: only a write may empty-to-full the buffer
    a_r4_fall_needs_write: assert property (@(posedge clk) disable iff (rst)
        $fell(empty_q) |-> $past(wr_en));

    // R5: the shift stage takes only real data
    a_r5_take_needs_data: assert property (@(posedge clk) disable iff (rst)
        take |-> !empty_q);

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   baud_tick,
    input  logic   load,
    input  frame_t frame_in,
    output logic   busy,
    output logic   txd_bit,
    output logic   done
);

    localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;

    logic [FW-1:0] sh_q;
    logic [LW-1:0] left_q;
    logic [TW-1:0] tcnt_q;
    logic          busy_q;
    logic          bit_end;

    assign bit_end = busy_q && baud_tick && (tcnt_q == TW'(OVS - 1));
    assign done    = bit_end && (left_q == LW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sh_q   <= '1;
            left_q <= '0;
            tcnt_q <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            sh_q   <= frame_in.bits;
            left_q <= frame_in.len;
            tcnt_q <= '0;
        end else if (busy_q && baud_tick) begin
            if (bit_end) begin
                tcnt_q <= '0;
                sh_q   <= {1'b1, sh_q[FW-1:1]};
                left_q <= left_q - LW'(1);
                if (left_q == LW'(1)) busy_q <= 1'b0;
            end else begin
                tcnt_q <= tcnt_q + TW'(1);
            end
        end
    end

    assign busy    = busy_q;
    assign txd_bit = busy_q ? sh_q[0] : 1'b1;

    // R6: a new frame never cuts into a running one
    a_r6_load_only_idle: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy_q);

    // R2: bit pattern frozen between baud ticks
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        busy_q && !baud_tick |=> $stable(sh_q));

endmodule

// File: rtl/utx_txc.sv
module utx_txc (
    input  logic clk,
    input  logic rst,
    input  logic frame_done,
    input  logic buf_empty,
    input  logic ack,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)                          flag_q <= 1'b0;
        else if (frame_done && buf_empty) flag_q <= 1'b1;
        else if (ack || clr)              flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R7: the flag rises only at the end of a frame
    a_r7_set_at_frame_end: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(frame_done));

    // R8: acknowledge or write-one clears the flag
    a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
        flag_q && (ack || clr) && !frame_done |=> !flag_q);

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import utx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic [1:0] fmt_width,
    input  logic       fmt_par_en,
    input  logic       fmt_par_odd,
    input  logic       fmt_stop2,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       txc_clr,
    input  logic       txc_ack,
    input  logic       ie_empty,
    input  logic       ie_txc,
    input  logic       baud_tick,
    output logic       txd,
    output logic       txd_oe,
    output logic       flag_empty,
    output logic       flag_txc,
    output logic       irq_empty,
    output logic       irq_txc
);

    fmt_t          fmt;
    frame_t        frame;
    logic [DW-1:0] buf_data;
    logic          buf_empty;
    logic          busy;
    logic          txd_bit;
    logic          done;
    logic          load;
    logic          active_q;
    logic          txc_q;

    assign fmt.width   = width_e'(fmt_width);
    assign fmt.par_en  = fmt_par_en;
    assign fmt.par_odd = fmt_par_odd;
    assign fmt.stop2   = fmt_stop2;

    assign frame = build_frame(buf_data, fmt);
    assign load  = active_q && !busy && !buf_empty;

    // the transmitter stays on until nothing is left to send
    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= tx_en || (active_q && (busy || !buf_empty));
    end

    utx_holdbuf u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load),
        .data    (buf_data),
        .empty   (buf_empty)
    );

    utx_shifter #(.OVS(OVS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .load      (load),
        .frame_in  (frame),
        .busy      (busy),
        .txd_bit   (txd_bit),
        .done      (done)
    );

    utx_txc u_txc (
        .clk        (clk),
        .rst        (rst),
        .frame_done (done),
        .buf_empty  (buf_empty),
        .ack        (txc_ack),
        .clr        (txc_clr),
        .flag       (txc_q)
    );

    assign txd        = active_q ? txd_bit : 1'b1;
    assign txd_oe     = active_q;
    assign flag_empty = buf_empty;
    assign flag_txc   = txc_q;
    assign irq_empty  = ie_empty && buf_empty;
    assign irq_txc    = ie_txc && txc_q;

    // R11: the pin is released only after buffer and shifter drained
    a_r11_release_after_drain: assert property (@(posedge clk) disable iff (rst)
        $fell(txd_oe) |-> $past(buf_empty) && !$past(busy));

    // R7: completion reported only with an idle shift stage
    a_r7_complete_when_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_txc) |-> !busy && $past(buf_empty));

endmodule

// File: tb/tb_uart_tx_dbuf.sv
module tb_uart_tx_dbuf;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic [1:0] fmt_width = 2'd3;
    logic       fmt_par_en = 1'b0;
    logic       fmt_par_odd = 1'b0;
    logic       fmt_stop2 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       txc_clr = 1'b0;
    logic       txc_ack = 1'b0;
    logic       ie_empty = 1'b0;
    logic       ie_txc = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd, txd_oe, flag_empty, flag_txc, irq_empty, irq_txc;

    int checks = 0;
    int fails  = 0;
    int tick_p = 1;
    int tcnt   = 0;
    int cycles = 0;

    logic [7:0] exp_q[$];
    logic       rx_bits[12];
    int         m_busy = 0, m_cnt = 0, m_idx = 0, m_next = 0;
    int         frames_done = 0;

    uart_tx_dbuf dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .fmt_width(fmt_width),
        .fmt_par_en(fmt_par_en), .fmt_par_odd(fmt_par_odd), .fmt_stop2(fmt_stop2),
        .wr_en(wr_en), .wr_data(wr_data), .txc_clr(txc_clr), .txc_ack(txc_ack),
        .ie_empty(ie_empty), .ie_txc(ie_txc), .baud_tick(baud_tick),
        .txd(txd), .txd_oe(txd_oe), .flag_empty(flag_empty), .flag_txc(flag_txc),
        .irq_empty(irq_empty), .irq_txc(irq_txc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nbits();
        return 5 + int'(fmt_width);
    endfunction

    function automatic int exp_len();
        return 1 + nbits() + (fmt_par_en ? 1 : 0) + (fmt_stop2 ? 2 : 1);
    endfunction

    function automatic logic exp_parity(logic [7:0] d);
        logic p = fmt_par_odd;
        for (int i = 0; i < nbits(); i++) p = p ^ d[i];
        return p;
    endfunction

    task automatic check_frame();
        logic [7:0] got = 8'd0;
        logic [7:0] e;
        int n = nbits();
        int pos;
        for (int i = 0; i < n; i++) got[i] = rx_bits[1+i];
        chk(rx_bits[0] == 1'b0, "R2 start bit", int'(rx_bits[0]), 0);
        if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected frame", int'(got), -1);
            return;
        end
        e = exp_q.pop_front() & 8'((1 << n) - 1);
        chk(got == e, "R2 data bits", int'(got), int'(e));
        pos = 1 + n;
        if (fmt_par_en) begin
            chk(rx_bits[pos] == exp_parity(e), "R3 parity bit",
                int'(rx_bits[pos]), int'(exp_parity(e)));
            pos++;
        end
        chk(rx_bits[pos] == 1'b1, "R2 stop bit", int'(rx_bits[pos]), 1);
        if (fmt_stop2) chk(rx_bits[pos+1] == 1'b1, "R2 second stop", int'(rx_bits[pos+1]), 1);
        frames_done++;
    endtask

    // baud generator and line monitor, both on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (m_busy != 0) begin
                m_cnt++;
                if (m_cnt == m_next) begin
                    rx_bits[m_idx] = txd;
                    m_idx++;
                    m_next = m_next + 16 * tick_p;
                    if (m_idx == exp_len()) begin
                        check_frame();
                        m_busy = 0;
                    end
                end
            end else if (txd_oe && txd === 1'b0) begin
                m_busy = 1; m_cnt = 0; m_idx = 0; m_next = 8 * tick_p;
            end
        end
        if (tcnt + 1 >= tick_p) begin tcnt = 0; baud_tick = 1'b1; end
        else begin tcnt++; baud_tick = 1'b0; end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b; exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_txc();
        while (!flag_txc) @(negedge clk);
    endtask

    task automatic clear_txc();
        txc_clr = 1'b1;
        @(negedge clk);
        txc_clr = 1'b0;
        chk(flag_txc == 1'b0, "R8 clear by write-one", int'(flag_txc), 0);
    endtask

    initial begin
        int snap;
        void'($urandom(32'd20240611));
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        chk(txd_oe == 1'b0, "R1 oe low", int'(txd_oe), 0);
        chk(flag_empty == 1'b1, "R1 empty set", int'(flag_empty), 1);
        chk(flag_txc == 1'b0, "R1 txc clear", int'(flag_txc), 0);
        chk(irq_txc == 1'b0, "R1 irq_txc low", int'(irq_txc), 0);

        // R4: other inputs leave flag_empty alone
        txc_ack = 1'b1; txc_clr = 1'b1; ie_txc = 1'b1; cyc(2);
        txc_ack = 1'b0; txc_clr = 1'b0; ie_txc = 1'b0; cyc(1);
        chk(flag_empty == 1'b1, "R4 no clear by ack/clr", int'(flag_empty), 1);
        // R9 level request
        ie_empty = 1'b1; cyc(1);
        chk(irq_empty == 1'b1, "R9 irq with empty", int'(irq_empty), 1);

        // R4: write while disabled is held
        do_write(8'hA5);
        chk(flag_empty == 1'b0, "R4 write clears empty", int'(flag_empty), 0);
        chk(irq_empty == 1'b0, "R9 irq drops", int'(irq_empty), 0);
        cyc(3);
        chk(txd_oe == 1'b0 && txd == 1'b1, "R11 held while disabled", int'(txd_oe), 0);
        chk(flag_empty == 1'b0, "R4 data held", int'(flag_empty), 0);
        tx_en = 1'b1;
        cyc(1);
        chk(txd_oe == 1'b1, "R11 oe rises", int'(txd_oe), 1);
        cyc(1);
        chk(flag_empty == 1'b1, "R5 handover after enable", int'(flag_empty), 1);
        wait_txc();
        chk(frames_done == 1, "R7 first frame", frames_done, 1);
        clear_txc();

        // R5 exact handover timing
        do_write(8'h3C);
        chk(flag_empty == 1'b0, "R5 empty low after write", int'(flag_empty), 0);
        cyc(1);
        chk(flag_empty == 1'b1, "R5 empty high at load", int'(flag_empty), 1);
        chk(txd == 1'b0, "R5 start bit begins", int'(txd), 0);
        ie_txc = 1'b1;
        wait_txc();
        chk(irq_txc == 1'b1, "R10 irq_txc", int'(irq_txc), 1);
        txc_ack = 1'b1; cyc(1); txc_ack = 1'b0;
        chk(flag_txc == 1'b0, "R8 clear by ack", int'(flag_txc), 0);
        chk(irq_txc == 1'b0, "R10 irq_txc drops", int'(irq_txc), 0);

        // R6/R7 back to back
        snap = frames_done;
        do_write(8'h81);
        cyc(1);
        do_write(8'h7E);
        chk(flag_empty == 1'b0, "R6 second byte waits", int'(flag_empty), 0);
        cyc(40);
        chk(flag_empty == 1'b0 && flag_txc == 1'b0, "R6 still buffered", int'(flag_empty), 0);
        wait_txc();
        chk(frames_done - snap == 2, "R7 no txc between frames", frames_done - snap, 2);
        clear_txc();

        // R11 drain before release
        snap = frames_done;
        fmt_par_en = 1'b1; fmt_par_odd = 1'b1; fmt_width = 2'd0; fmt_stop2 = 1'b1;
        do_write(8'h13);
        cyc(1);
        do_write(8'h0E);
        tx_en = 1'b0;
        cyc(1);
        chk(txd_oe == 1'b1, "R11 oe held while pending", int'(txd_oe), 1);
        wait_txc();
        chk(txd_oe == 1'b1, "R11 oe at txc", int'(txd_oe), 1);
        cyc(1);
        chk(txd_oe == 1'b0 && txd == 1'b1, "R11 released", int'(txd_oe), 0);
        chk(frames_done - snap == 2, "R11 all frames sent", frames_done - snap, 2);
        clear_txc();
        tx_en = 1'b1;
        cyc(2);

        // random formats and rates
        for (int g = 0; g < 8; g++) begin
            fmt_width   = 2'($urandom % 4);
            fmt_par_en  = 1'($urandom % 2);
            fmt_par_odd = 1'($urandom % 2);
            fmt_stop2   = 1'($urandom % 2);
            tick_p      = 1 + int'($urandom % 3);
            snap = frames_done;
            for (int k = 0; k < 4; k++) begin
                while (!flag_empty) @(negedge clk);
                do_write(8'($urandom));
            end
            wait_txc();
            chk(frames_done - snap == 4, "R2 random group frames", frames_done - snap, 4);
            clear_txc();
        end
        chk(exp_q.size() == 0, "R6 all bytes sent", exp_q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule